// File: doc/BRIEF.md
# Software Interrupt Pending Register with Priority-Level Gating

This block holds the pending software-interrupt bits of one hardware thread and turns them into a vector of interrupt requests for the trap logic. Software changes the register through one write port that works in three ways: it can replace the whole register, OR a mask into it, or clear the bits named by a mask. The last two are single-cycle read-modify-write updates, so a handler can touch its own bits without a read-back race.

Two timer-match pulses from outside set their reserved bits directly. The low tick match sets bit 0 and the system tick match sets bit 16. Each bit reaches the request vector only when the current processor interrupt level (PIL) allows it. Bits 1 to 15 are compared against the PIL by their own index. The two timer bits share a fixed threshold of 14. The raw register can be read back at any time.

Top module: `soft_irq_pend`

## Requirements
- R1: A synchronous active-high reset clears the register to zero, so read-back and requests are all zero in the cycle after reset.
- R2: With write enable high and write kind 0 (direct), the register takes write-data bits 16..0 at the next clock edge. Write-data bits above 16 are ignored, and read-back bits above 16 are always zero.
- R3: With write enable high and write kind 1 (set), the register becomes its old value ORed with write-data bits 16..0.
- R4: With write enable high and write kind 2 (clear), the register becomes its old value ANDed with the inverse of write-data bits 16..0.
- R5: For each n from 1 to 15, request bit n is high exactly when register bit n is set and n is strictly greater than the PIL.
- R6: Request bit 0 is high exactly when register bit 0 is set and the PIL is below 14.
- R7: Request bit 16 is high exactly when register bit 16 is set and the PIL is below 14.
- R8: A high tick-match pulse sets bit 0 and a high system-tick-match pulse sets bit 16 at the next edge. This set wins over a direct write or a clear of the same bit in that cycle.
- R9: When write enable is low and no match pulse arrives, the register keeps its value. Write kind 3 is reserved and changes nothing.
- R10: The request vector follows a PIL change within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | 0 direct, 1 set, 2 clear, 3 reserved |
| wr_data | input | DATA_W | Write value or mask; only bits 16..0 are used |
| pil | input | PIL_W | Current processor interrupt level |
| tick_hit | input | 1 | Tick-match pulse, sets bit 0 |
| stick_hit | input | 1 | System-tick-match pulse, sets bit 16 |
| rd_val | output | DATA_W | Raw register value, zero above bit 16 |
| irq_post | output | NB | Requests allowed by the PIL |

## Verification
The register is the only state in the block. A wrong update from a set, clear or direct write therefore shows up on the read-back port in the very next cycle, and it is checked there for each write kind. A gating error has no state behind it, so it appears on the request vector in the same cycle as the PIL value that exposes it. For that reason the bench sweeps all sixteen PIL values against a full register without clocking. The case where a match pulse and a clear hit the same bit is driven directly, so that the wrong winner would be visible at once.

// File: rtl/softint_pkg.sv
package softint_pkg;
  localparam int SI_BITS = 17;

  typedef enum logic [1:0] {
    WR_DIRECT = 2'd0,
    WR_SET    = 2'd1,
    WR_CLEAR  = 2'd2,
    WR_NONE   = 2'd3
  } wr_kind_e;

  // Software-side next value of the pending register.
  function automatic logic [SI_BITS-1:0] sw_update(
    input logic               en,
    input wr_kind_e           kind,
    input logic [SI_BITS-1:0] cur,
    input logic [SI_BITS-1:0] wdat
  );
    if (!en) return cur;
    case (kind)
      WR_DIRECT: return wdat;
      WR_SET:    return cur | wdat;
      WR_CLEAR:  return cur & ~wdat;
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/softint_store.sv
module softint_store
  import softint_pkg::*;
#(
  parameter int NB = SI_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  wr_kind_e      wr_kind,
  input  logic [NB-1:0] wr_low,
  input  logic [NB-1:0] hw_set,
  output logic [NB-1:0] sw_nxt,
  output logic [NB-1:0] pend_q
);
  // Hardware sets are ORed in after the software update, so they win.
  assign sw_nxt = sw_update(wr_en, wr_kind, pend_q, wr_low);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= sw_nxt | hw_set;
  end
endmodule

// File: rtl/softint_gate.sv
module softint_gate #(
  parameter int NB       = 17,
  parameter int PIL_W    = 4,
  parameter int EDGE_PIL = 14
) (
  input  logic [NB-1:0]    pend,
  input  logic [PIL_W-1:0] pil,
  output logic [NB-1:0]    elig,
  output logic [NB-1:0]    post
);
  for (genvar b = 0; b < NB; b++) begin : g_bit
    if (b == 0 || b == NB - 1) begin : g_timer
      assign elig[b] = 32'(pil) < 32'(EDGE_PIL);
    end else begin : g_level
      assign elig[b] = 32'(pil) < 32'(b);
    end
  end

  assign post = pend & elig;
endmodule

// File: rtl/soft_irq_pend.sv
module soft_irq_pend
  import softint_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NB       = SI_BITS,
  parameter int PIL_W    = 4,
  parameter int EDGE_PIL = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PIL_W-1:0]  pil,
  input  logic              tick_hit,
  input  logic              stick_hit,
  output logic [DATA_W-1:0] rd_val,
  output logic [NB-1:0]     irq_post
);
  localparam int PAD_W = DATA_W - NB;

  logic [NB-1:0] hw_set;
  logic [NB-1:0] sw_nxt;
  logic [NB-1:0] pend_q;
  logic [NB-1:0] elig;

  assign hw_set = {stick_hit, {(NB-2){1'b0}}, tick_hit};

  softint_store #(.NB(NB)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_kind (wr_kind_e'(wr_kind)),
    .wr_low  (wr_data[NB-1:0]),
    .hw_set  (hw_set),
    .sw_nxt  (sw_nxt),
    .pend_q  (pend_q)
  );

  softint_gate #(.NB(NB), .PIL_W(PIL_W), .EDGE_PIL(EDGE_PIL)) u_gate (
    .pend (pend_q),
    .pil  (pil),
    .elig (elig),
    .post (irq_post)
  );

  assign rd_val = {{PAD_W{1'b0}}, pend_q};
endmodule

// File: rtl/softint_chk.sv
module softint_chk #(
  parameter int DATA_W   = 64,
  parameter int NB       = 17,
  parameter int PIL_W    = 4,
  parameter int EDGE_PIL = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_kind,
  input logic [DATA_W-1:0] wr_data,
  input logic [PIL_W-1:0]  pil,
  input logic              tick_hit,
  input logic              stick_hit,
  input logic [DATA_W-1:0] rd_val,
  input logic [NB-1:0]     irq_post
);
  logic [NB-1:0] hw;
  logic          quiet;
  assign hw    = {stick_hit, {(NB-2){1'b0}}, tick_hit};
  assign quiet = !tick_hit && !stick_hit;

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_val[DATA_W-1:NB] == '0); // R2
  AST_SET_OR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kind == 2'd1) |=> rd_val[NB-1:0] ==
      ($past(rd_val[NB-1:0]) | $past(wr_data[NB-1:0]) | $past(hw))); // R3
  AST_CLEAR_ANDN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kind == 2'd2 && quiet) |=> rd_val[NB-1:0] ==
      ($past(rd_val[NB-1:0]) & ~$past(wr_data[NB-1:0]))); // R4
  AST_POST_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (irq_post & ~rd_val[NB-1:0]) == '0); // R5
  AST_TIMER_GATE: assert property (@(posedge clk) disable iff (rst)
    (32'(pil) >= 32'(EDGE_PIL)) |-> (!irq_post[0] && !irq_post[NB-1])); // R6
  AST_STICK_POST: assert property (@(posedge clk) disable iff (rst)
    (rd_val[NB-1] && 32'(pil) < 32'(EDGE_PIL)) |-> irq_post[NB-1]); // R7
  AST_HW_WINS: assert property (@(posedge clk) disable iff (rst)
    (tick_hit && stick_hit) |=> (rd_val[0] && rd_val[NB-1])); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && quiet) |=> $stable(rd_val)); // R9
endmodule

bind soft_irq_pend softint_chk #(
  .DATA_W(DATA_W), .NB(NB), .PIL_W(PIL_W), .EDGE_PIL(EDGE_PIL)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_data(wr_data),
  .pil(pil), .tick_hit(tick_hit), .stick_hit(stick_hit),
  .rd_val(rd_val), .irq_post(irq_post)
);

// File: tb/soft_irq_pend_tb.sv
`timescale 1ns/1ps
module soft_irq_pend_tb;
  localparam int DW = 64;
  localparam int NB = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_kind = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic [3:0]    pil = 4'd0;
  logic          tick_hit = 1'b0;
  logic          stick_hit = 1'b0;
  logic [DW-1:0] rd_val;
  logic [NB-1:0] irq_post;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  soft_irq_pend u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_data(wr_data),
    .pil(pil), .tick_hit(tick_hit), .stick_hit(stick_hit),
    .rd_val(rd_val), .irq_post(irq_post)
  );

  typedef struct packed {
    logic        en;
    logic [1:0]  kind;
    logic [16:0] data;
    logic [3:0]  lvl;
    logic        tk;
    logic        stk;
    logic [16:0] exp_reg;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 17'h1FFFF, 4'd0,  1'b0, 1'b0, 17'h1FFFF},  // R2 direct
    '{1'b1, 2'd2, 17'h0F0F0, 4'd5,  1'b0, 1'b0, 17'h10F0F},  // R4 clear
    '{1'b1, 2'd1, 17'h02000, 4'd13, 1'b0, 1'b0, 17'h12F0F},  // R3 set
    '{1'b0, 2'd0, 17'h00000, 4'd14, 1'b0, 1'b0, 17'h12F0F},  // R9 hold
    '{1'b1, 2'd2, 17'h1FFFF, 4'd15, 1'b1, 1'b0, 17'h00001},  // R8 tick over clear
    '{1'b1, 2'd0, 17'h00000, 4'd3,  1'b0, 1'b1, 17'h10000},  // R8 stick over direct
    '{1'b1, 2'd1, 17'h08004, 4'd2,  1'b0, 1'b0, 17'h18004},  // R3 set
    '{1'b1, 2'd3, 17'h1FFFF, 4'd7,  1'b0, 1'b0, 17'h18004},  // R9 reserved kind
    '{1'b0, 2'd0, 17'h00000, 4'd15, 1'b1, 1'b0, 17'h18005},  // R8 tick alone
    '{1'b1, 2'd2, 17'h18005, 4'd0,  1'b0, 1'b0, 17'h00000}   // R4 clear all
  };

  // Expected request vector, rebuilt bit by bit from R5 to R7.
  function automatic logic [NB-1:0] want_post(logic [NB-1:0] r, logic [3:0] lvl);
    logic [NB-1:0] o = '0;
    for (int n = 0; n < NB; n++) begin
      if (n == 0 || n == 16) o[n] = r[n] && (lvl < 4'd14);
      else                   o[n] = r[n] && (n > int'(lvl));
    end
    return o;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 5000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    rst = 1'b0;
    chk("R1 reset reg", rd_val, '0);
    chk("R1 reset post", {47'b0, irq_post}, '0);

    // Vector table walk.
    for (int i = 0; i < NV; i++) begin
      wr_en = VECS[i].en; wr_kind = VECS[i].kind;
      wr_data = {47'b0, VECS[i].data}; pil = VECS[i].lvl;
      tick_hit = VECS[i].tk; stick_hit = VECS[i].stk;
      step();
      wr_en = 1'b0; tick_hit = 1'b0; stick_hit = 1'b0;
      chk($sformatf("R2/R3/R4/R8/R9 row %0d reg", i), rd_val, {47'b0, VECS[i].exp_reg});
      chk($sformatf("R5/R6/R7 row %0d post", i), {47'b0, irq_post},
          {47'b0, want_post(VECS[i].exp_reg, VECS[i].lvl)});
    end

    // R2: upper write-data bits ignored, read back as zero.
    wr_en = 1'b1; wr_kind = 2'd0; wr_data = '1;
    step();
    wr_en = 1'b0;
    chk("R2 upper bits zero", rd_val, 64'h1FFFF);

    // R10: sweep the PIL with no clock edge between change and check.
    for (int l = 0; l < 16; l++) begin
      pil = 4'(l);
      #0.5;
      chk($sformatf("R10 R5 R6 R7 pil=%0d", l), {47'b0, irq_post},
          {47'b0, want_post(17'h1FFFF, 4'(l))});
    end

    // R8: system tick match against a clear of bit 16 in the same cycle.
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'd2; wr_data = 64'h10000; stick_hit = 1'b1;
    step();
    wr_en = 1'b0; stick_hit = 1'b0;
    chk("R8 stick beats clear", rd_val, 64'h1FFFF);

    // R4 then R7: clear all but bit 16, pil 13 posts, pil 14 masks.
    wr_en = 1'b1; wr_kind = 2'd2; wr_data = 64'h0FFFF; pil = 4'd13;
    step();
    wr_en = 1'b0;
    chk("R7 bit16 posted at pil 13", {47'b0, irq_post}, 64'h10000);
    pil = 4'd14;
    #0.5;
    chk("R7 bit16 masked at pil 14", {47'b0, irq_post}, 64'h0);

    // R1: reset in mid-run clears the register.
    @(negedge clk);
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R1 mid-run reset", rd_val, '0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule